// File: doc/BRIEF.md
# Multiframe Clock Phase Aligner

This block generates the frame pulse and the multiframe pulse that a high-speed converter link needs for deterministic latency. Both pulses come from the device clock, which is qualified by a clock-enable input. The octets per frame and the frames per multiframe are set by configuration inputs. The block runs an octet counter and a frame counter. It drives a one-cycle pulse each time a frame starts and another each time a multiframe starts.

A 2-bit subclass input selects the reference used to set the multiframe phase. In subclass 0 the counters run free from reset. In subclass 1 a rising edge of the system reference input restarts both counters. In subclass 2 the release of the active-low sync request restarts them. Both references are first passed through a two-flop synchronizer. A sticky status output reports that the phase has been set. A one-shot option lets system software accept a single reference edge each time it arms the block.

Top module: `mfclk_phase_align`

## Requirements
- R1: Counter state changes only on clock edges where `clk_en` is 1. `frame_pulse` and `mf_pulse` are high for exactly one clock after an enabled edge and are low after any edge where `clk_en` is 0.
- R2: `frame_pulse` is high after every enabled edge at which the octet position becomes 0. With no alignment event, this repeats every `cfg_opf_m1`+1 enabled edges, where `cfg_opf_m1` takes values 0..15 for 1 to 16 octets per frame.
- R3: `mf_pulse` is high only together with `frame_pulse`, and only when the frame position is also 0. With no alignment event its period is (`cfg_opf_m1`+1)·(`cfg_fpm_m1`+1) enabled edges, where `cfg_fpm_m1` takes values 0..31 for 1 to 32 frames.
- R4: While `rst` is high, both pulses and `aligned` are 0 and the counters are held at octet 0, frame 0. The first enabled edge after reset advances them as in R2 and R3.
- R5: Subclass 1 is code 2'b01. If `sysref` is first sampled high at enabled edge k after being sampled low, both counters restart at 0 at enabled edge k+2. Both pulses are then high after that edge, and counting resumes from there.
- R6: Subclass 2 is code 2'b10. A low-to-high transition of `sync_n` has the same latency and effect as in R5. `sysref` has no effect in this subclass. The synchronizer for `sync_n` resets to 1, so holding `sync_n` high creates no event.
- R7: Subclass 0 is code 2'b00. `sysref` and `sync_n` have no effect, and the counters run free from reset. `aligned` goes to 1 on the first clock edge after reset release.
- R8: In subclasses 1 and 2, `aligned` goes to 1 with the first accepted event and stays 1 until reset. Subclass code 2'b11 is reserved: it accepts no events and never sets `aligned`.
- R9: An event that lands on the enabled edge where the counters would wrap to octet 0, frame 0 anyway leaves the pulse train unchanged. No pulse is added and no pulse is removed.
- R10: With `oneshot_en` = 1, a `sysref` edge is accepted only if `arm` was high on some enabled edge since the last accepted edge. Later edges are ignored until `arm` is seen again.
- R11: With `oneshot_en` = 0, every `sysref` rising edge in subclass 1 realigns the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Device-clock enable; qualifies every state change |
| sysref | input | 1 | Asynchronous system reference |
| sync_n | input | 1 | Asynchronous active-low sync request |
| subclass | input | 2 | 0 free-run, 1 reference edge, 2 sync release, 3 reserved |
| cfg_opf_m1 | input | OCT_W (4) | Octets per frame minus one |
| cfg_fpm_m1 | input | FRM_W (5) | Frames per multiframe minus one |
| oneshot_en | input | 1 | Accept one reference edge per arm |
| arm | input | 1 | Arms the one-shot reference acceptance |
| frame_pulse | output | 1 | Frame start pulse |
| mf_pulse | output | 1 | Multiframe start pulse |
| aligned | output | 1 | Sticky phase-set status |

## Verification
The assertions assume that `subclass`, `oneshot_en` and both configuration inputs are changed only while reset is high. They also assume that `rst` is high from time zero. The stimulus reapplies reset before every configuration change and changes `clk_en`, `sysref`, `sync_n` and `arm` only on falling clock edges. Reference and sync pulses are held for several enabled edges, so the synchronizer always sees a clean level change.

// File: rtl/mfclk_pkg.sv
package mfclk_pkg;
  typedef enum logic [1:0] {
    SC_FREE      = 2'd0,
    SC_REF_EDGE  = 2'd1,
    SC_SYNC_REL  = 2'd2,
    SC_RESERVED  = 2'd3
  } subclass_e;
endpackage

// File: rtl/mfclk_sync.sv
module mfclk_sync #(
  parameter int                 WIDTH   = 2,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        pipe[g] <= RST_VAL;
      end else if (en) begin
        if (g == 0) pipe[g] <= d;
        else        pipe[g] <= pipe[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/mfclk_event_sel.sv
module mfclk_event_sel
  import mfclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       ref_s,
  input  logic       syn_s,
  input  logic [1:0] subclass,
  input  logic       oneshot_en,
  input  logic       arm,
  output logic       align_ev
);
  logic ref_d, syn_d, armed;
  logic ref_rise, syn_rise, ref_acc;
  subclass_e mode;

  assign mode     = subclass_e'(subclass);
  assign ref_rise = ref_s & ~ref_d;
  assign syn_rise = syn_s & ~syn_d;
  assign ref_acc  = en && (mode == SC_REF_EDGE) && ref_rise && (!oneshot_en || armed);

  always_comb begin
    align_ev = 1'b0;
    if (en) begin
      case (mode)
        SC_REF_EDGE: align_ev = ref_acc;
        SC_SYNC_REL: align_ev = syn_rise;
        default:     align_ev = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_d <= 1'b0;
      syn_d <= 1'b1;
      armed <= 1'b0;
    end else if (en) begin
      ref_d <= ref_s;
      syn_d <= syn_s;
      if (arm)                        armed <= 1'b1;
      else if (ref_acc && oneshot_en) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/mfclk_counters.sv
module mfclk_counters #(
  parameter int OCT_W = 4,
  parameter int FRM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             align,
  input  logic [OCT_W-1:0] opf_m1,
  input  logic [FRM_W-1:0] fpm_m1,
  output logic             frame_pulse,
  output logic             mf_pulse
);
  logic [OCT_W-1:0] oct_q, oct_n;
  logic [FRM_W-1:0] frm_q, frm_n;

  always_comb begin
    oct_n = oct_q;
    frm_n = frm_q;
    if (align) begin
      oct_n = '0;
      frm_n = '0;
    end else if (oct_q >= opf_m1) begin
      oct_n = '0;
      frm_n = (frm_q >= fpm_m1) ? '0 : frm_q + 1'b1;
    end else begin
      oct_n = oct_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oct_q       <= '0;
      frm_q       <= '0;
      frame_pulse <= 1'b0;
      mf_pulse    <= 1'b0;
    end else begin
      frame_pulse <= 1'b0;
      mf_pulse    <= 1'b0;
      if (en) begin
        oct_q       <= oct_n;
        frm_q       <= frm_n;
        frame_pulse <= (oct_n == '0);
        mf_pulse    <= (oct_n == '0) && (frm_n == '0);
      end
    end
  end
endmodule

// File: rtl/mfclk_phase_align.sv
module mfclk_phase_align
  import mfclk_pkg::*;
#(
  parameter int OCT_W       = 4,
  parameter int FRM_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             sysref,
  input  logic             sync_n,
  input  logic [1:0]       subclass,
  input  logic [OCT_W-1:0] cfg_opf_m1,
  input  logic [FRM_W-1:0] cfg_fpm_m1,
  input  logic             oneshot_en,
  input  logic             arm,
  output logic             frame_pulse,
  output logic             mf_pulse,
  output logic             aligned
);
  localparam int         NREF     = 2;
  localparam logic [1:0] SYNC_RST = 2'b10;

  logic [NREF-1:0] ref_raw, ref_sy;
  logic            align_ev;

  assign ref_raw = {sync_n, sysref};

  mfclk_sync #(.WIDTH(NREF), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .en  (clk_en),
    .d   (ref_raw),
    .q   (ref_sy)
  );

  mfclk_event_sel u_evsel (
    .clk        (clk),
    .rst        (rst),
    .en         (clk_en),
    .ref_s      (ref_sy[0]),
    .syn_s      (ref_sy[1]),
    .subclass   (subclass),
    .oneshot_en (oneshot_en),
    .arm        (arm),
    .align_ev   (align_ev)
  );

  mfclk_counters #(.OCT_W(OCT_W), .FRM_W(FRM_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .en          (clk_en),
    .align       (align_ev),
    .opf_m1      (cfg_opf_m1),
    .fpm_m1      (cfg_fpm_m1),
    .frame_pulse (frame_pulse),
    .mf_pulse    (mf_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)                                           aligned <= 1'b0;
    else if (subclass_e'(subclass) == SC_FREE || align_ev) aligned <= 1'b1;
  end
endmodule

// File: rtl/mfclk_phase_align_chk.sv
module mfclk_phase_align_chk (
  input logic       clk,
  input logic       rst,
  input logic       clk_en,
  input logic [1:0] subclass,
  input logic       frame_pulse,
  input logic       mf_pulse,
  input logic       aligned
);
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |-> $past(clk_en)); // R1
  AST_MF_WITH_FRAME: assert property (@(posedge clk) disable iff (rst)
    mf_pulse |-> frame_pulse); // R3
  AST_ALIGNED_STICKY: assert property (@(posedge clk) disable iff (rst)
    aligned |=> aligned); // R8
  AST_FREE_ALIGNS: assert property (@(posedge clk) disable iff (rst)
    (subclass == 2'd0) |=> aligned); // R7
  AST_RSVD_NO_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (subclass == 2'd3 && !aligned) |=> !aligned); // R8
endmodule

bind mfclk_phase_align mfclk_phase_align_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .clk_en      (clk_en),
  .subclass    (subclass),
  .frame_pulse (frame_pulse),
  .mf_pulse    (mf_pulse),
  .aligned     (aligned)
);

// File: tb/mfclk_phase_align_bench.sv
module mfclk_phase_align_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b1, sysref = 1'b0, sync_n = 1'b1;
  logic [1:0] subclass = 2'd0;
  logic [3:0] cfg_opf_m1 = 4'd0;
  logic [4:0] cfg_fpm_m1 = 5'd0;
  logic       oneshot_en = 1'b0, arm = 1'b0;
  logic       frame_pulse, mf_pulse, aligned;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mfclk_phase_align u_mfclk_phase_align (
    .clk(clk), .rst(rst), .clk_en(clk_en), .sysref(sysref), .sync_n(sync_n),
    .subclass(subclass), .cfg_opf_m1(cfg_opf_m1), .cfg_fpm_m1(cfg_fpm_m1),
    .oneshot_en(oneshot_en), .arm(arm),
    .frame_pulse(frame_pulse), .mf_pulse(mf_pulse), .aligned(aligned)
  );

  // Expected-behaviour model built from the requirements
  bit m_r1, m_r2, m_rd, m_y1, m_y2, m_yd;
  int m_oct, m_frm, en_edges;
  bit m_fp, m_mp, m_al, m_armed;

  task automatic model_step();
    bit rise_r, rise_y, acc, ev;
    if (rst) begin
      m_r1 = 0; m_r2 = 0; m_rd = 0; m_y1 = 1; m_y2 = 1; m_yd = 1;
      m_oct = 0; m_frm = 0; m_fp = 0; m_mp = 0; m_al = 0; m_armed = 0;
      en_edges = 0;
      return;
    end
    ev = 0; acc = 0;
    if (clk_en) begin
      rise_r = m_r2 && !m_rd;
      rise_y = m_y2 && !m_yd;
      acc = (subclass == 2'd1) && rise_r && (!oneshot_en || m_armed);
      ev  = acc || ((subclass == 2'd2) && rise_y);
    end
    if (subclass == 2'd0 || ev) m_al = 1;
    if (clk_en) begin
      en_edges++;
      if (arm) m_armed = 1;
      else if (acc && oneshot_en) m_armed = 0;
      m_rd = m_r2; m_r2 = m_r1; m_r1 = sysref;
      m_yd = m_y2; m_y2 = m_y1; m_y1 = sync_n;
      if (ev) begin
        m_oct = 0; m_frm = 0;
      end else if (m_oct >= int'(cfg_opf_m1)) begin
        m_oct = 0;
        m_frm = (m_frm >= int'(cfg_fpm_m1)) ? 0 : m_frm + 1;
      end else begin
        m_oct++;
      end
      m_fp = (m_oct == 0);
      m_mp = (m_oct == 0) && (m_frm == 0);
    end else begin
      m_fp = 0; m_mp = 0;
    end
  endtask

  task automatic chk(input string tag, input bit act, input bit exp_v, input string what);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp_v, $time);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, frame_pulse, m_fp, "frame_pulse");
    chk(tag, mf_pulse, m_mp, "mf_pulse");
    chk(tag, aligned, m_al, "aligned");
  endtask

  task automatic do_reset(input logic [1:0] sc, input logic [3:0] opf, input logic [4:0] fpm, input bit os);
    rst = 1; subclass = sc; cfg_opf_m1 = opf; cfg_fpm_m1 = fpm; oneshot_en = os;
    clk_en = 1; sysref = 0; sync_n = 1; arm = 0;
    repeat (3) tick("R4");
    rst = 0;
  endtask

  task automatic trigger(input logic [1:0] kind, input string tag);
    if (kind == 2'd1) begin
      sysref = 1; repeat (3) tick(tag); sysref = 0;
    end else if (kind == 2'd2) begin
      sync_n = 0; repeat (4) tick(tag); sync_n = 1;
    end
  endtask

  // {subclass, opf_m1, fpm_m1, trigger kind (1 sysref, 2 sync), lead-in, oneshot}
  localparam logic [21:0] VEC [10] = '{
    {2'd0, 4'd3,  5'd3,  2'd1, 8'd10, 1'b0},
    {2'd0, 4'd0,  5'd0,  2'd2, 8'd5,  1'b0},
    {2'd1, 4'd3,  5'd1,  2'd1, 8'd9,  1'b0},
    {2'd1, 4'd15, 5'd31, 2'd1, 8'd7,  1'b0},
    {2'd1, 4'd0,  5'd4,  2'd1, 8'd3,  1'b0},
    {2'd2, 4'd2,  5'd2,  2'd2, 8'd11, 1'b0},
    {2'd2, 4'd1,  5'd3,  2'd1, 8'd6,  1'b0},
    {2'd3, 4'd2,  5'd1,  2'd1, 8'd5,  1'b0},
    {2'd3, 4'd2,  5'd1,  2'd2, 8'd5,  1'b0},
    {2'd1, 4'd4,  5'd2,  2'd2, 8'd8,  1'b0}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    string tag;
    model_step();
    // Reset state
    @(negedge clk);
    chk("R4", frame_pulse, 1'b0, "frame_pulse in reset");
    chk("R4", mf_pulse, 1'b0, "mf_pulse in reset");
    chk("R4", aligned, 1'b0, "aligned in reset");

    // Table walk: R2, R3, R5, R6, R7, R8, R11 per subclass
    foreach (VEC[i]) begin
      logic [21:0] v;
      v = VEC[i];
      case (v[21:20])
        2'd0: tag = "R7";
        2'd1: tag = "R5_R11";
        2'd2: tag = "R6";
        default: tag = "R8";
      endcase
      do_reset(v[21:20], v[19:16], v[15:11], v[0]);
      repeat (int'(v[8:1])) tick("R2_R3");
      trigger(v[10:9], tag);
      repeat (int'(v[8:1]) + 7) tick(tag);
      trigger(v[10:9], tag);
      repeat (80) tick(tag);
    end

    // R1: gated device clock
    do_reset(2'd0, 4'd2, 5'd2, 1'b0);
    for (int i = 0; i < 60; i++) begin
      clk_en = (i % 3 != 1) && (i % 7 != 5);
      tick("R1");
    end
    clk_en = 1;

    // R9: event landing on the natural wrap keeps the pulse train
    do_reset(2'd1, 4'd1, 5'd1, 1'b0);
    tick("R9");
    sysref = 1;
    for (int i = 0; i < 24; i++) begin
      if (i == 3) sysref = 0;
      tick("R9");
      chk("R9", mf_pulse, (en_edges % 4 == 0), "mf_pulse period 4");
    end
    chk("R9", aligned, 1'b1, "aligned after event");

    // R10: one-shot acceptance
    do_reset(2'd1, 4'd2, 5'd2, 1'b1);
    repeat (4) tick("R10");
    trigger(2'd1, "R10");
    repeat (6) tick("R10");
    chk("R10", aligned, 1'b0, "unarmed edge ignored");
    arm = 1; tick("R10"); arm = 0;
    repeat (3) tick("R10");
    trigger(2'd1, "R10");
    repeat (5) tick("R10");
    chk("R10", aligned, 1'b1, "armed edge accepted");
    repeat (4) tick("R10");
    trigger(2'd1, "R10");
    repeat (40) tick("R10");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule